// File: doc/BRIEF.md
# Transport Stream Packet Synchronizer

This block sits at the input of a transport stream receiver. Bytes arrive one per strobe, with an optional external start pulse. The block finds where each packet begins and marks the first and last byte of every packet on its output. It also raises a lock flag once a programmed number of start-byte matches has been seen. Software sets the start byte value, the packet length and the match count through one packed configuration word. Separate inputs set the start-pulse polarity, the framing mode and the start-pulse width.

Two framing schemes are available. In the edge modes, the rising edge of the external start input (after the polarity is applied) marks the next byte as a packet start. In byte-match mode the external input is ignored, and a packet starts on a byte equal to the programmed start value. The block then expects the next start exactly one packet length later. A missed start throws away lock and framing. A count of zero bypasses lock detection altogether. Any change to the configuration restarts both lock counting and framing.

Top module: `tsync_top`

## Requirements
- R1: The configuration word packs the required match count in bits 3:0, the packet length in bits 15:4 and the start byte value in bits 23:16.
- R2: While the required match count is zero, `in_sync` is 1 whatever bytes arrive.
- R3: With a nonzero count N in an edge mode, every input byte exactly equal to the start value counts as a match, in any byte position. `in_sync` becomes 1 together with the output of the N-th match. A byte of 0x2F does not match a start value of 0x47.
- R4: `cfg_mode` values 0, 1 and 2 are edge modes. In these modes a rising edge of the asserted external start marks a byte as a packet start, and a start in the middle of a packet restarts the byte count.
- R5: `cfg_pol`=0 makes `ext_sop` active high and `cfg_pol`=1 makes it active low. The edge that counts is the edge into the asserted level.
- R6: With `cfg_wide`=0, an edge on any clock since the previous byte marks the next byte, so a one-clock pulse between bytes counts. With `cfg_wide`=1, `ext_sop` is sampled only on byte strobes, and a pulse that falls between strobes is ignored.
- R7: The start byte is index 0, and `out_eop` marks index length-1. In edge modes, if the byte after an end does not carry a start, no markers appear until the next start.
- R8: `cfg_mode`=3 selects byte-match mode and `ext_sop` is ignored. While unframed, a start-value byte begins a packet. While framed, only a start-value byte at the expected start position is a start and counts as a match. Start-value bytes inside a packet do nothing.
- R9: In byte-match mode, a non-matching byte at the expected start position clears the match count and unframes the block. `in_sync` drops on that byte's output, and framing resumes at the next start-value byte.
- R10: A change to any configuration input clears the match count and the framing. No markers appear until a new start is found.
- R11: The outputs follow the input by one clock. `out_vld` copies `byte_vld`, `out_dat` holds the last valid byte, and markers appear only with `out_vld`.
- R12: While in reset, `out_vld`, `out_sop` and `out_eop` are 0, and `in_sync` is 0 unless the required count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Input byte strobe |
| byte_dat | input | DW | Input byte |
| ext_sop | input | 1 | External start-of-packet pulse |
| cfg_word | input | DW+LW+CW | {start value, length, match count} |
| cfg_pol | input | 1 | 1 = `ext_sop` active low |
| cfg_mode | input | 2 | 0..2 edge framing, 3 byte-match framing |
| cfg_wide | input | 1 | 1 = start pulse spans a byte time |
| out_vld | output | 1 | Output byte strobe |
| out_dat | output | DW | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| in_sync | output | 1 | Lock flag |

## Verification
The bench feeds 0x2F where 0x47 is programmed; a design that compared only some bits, or treated the value as a decimal number, would lock on it. In byte-match mode it places a start value inside a packet and toggles `ext_sop` there. A design that counted free-floating matches would lock early, and one that listened to the pin would mark stray starts. It also skips a start after a packet end, which must neither extend the packet nor keep lock, and it changes only the width bit in mid-packet to show that stale framing or a stale match count is dropped. Finally it sends one-clock pulses between byte strobes in both width settings, which a design that mixed the two settings up would mark wrongly.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
   localparam logic [1:0] MODE_BYTE_MATCH = 2'b11;

   function automatic logic is_match_mode(input logic [1:0] mode);
      return mode == MODE_BYTE_MATCH;
   endfunction
endpackage

// File: rtl/tsync_sop_detect.sv
module tsync_sop_detect #(
   parameter int HAS_EXT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic byte_vld,
   input  logic ext_sop,
   input  logic pol,
   input  logic wide,
   output logic sop_now
);
   generate
      if (HAS_EXT != 0) begin : g_ext
         logic act, prev_clk, prev_byt, pend, edge_clk;

         assign act      = ext_sop ^ pol;
         assign edge_clk = act & ~prev_clk;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prev_clk <= 1'b0;
               prev_byt <= 1'b0;
               pend     <= 1'b0;
            end else if (clr) begin
               prev_clk <= act;
               prev_byt <= act;
               pend     <= 1'b0;
            end else begin
               prev_clk <= act;
               if (byte_vld) prev_byt <= act;
               pend <= byte_vld ? 1'b0 : (pend | edge_clk);
            end
         end

         always_comb begin
            if (clr || !byte_vld) sop_now = 1'b0;
            else if (wide)        sop_now = act & ~prev_byt;
            else                  sop_now = pend | edge_clk;
         end

         // R6: a narrow edge seen on an idle clock must be consumed by the next byte
         p_pend_consumed_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (byte_vld && !clr && !wide && pend) |-> sop_now);
      end else begin : g_no_ext
         assign sop_now = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tsync_framer.sv
module tsync_framer #(
   parameter int DW = 8,
   parameter int LW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          byte_vld,
   input  logic [DW-1:0] byte_dat,
   input  logic [DW-1:0] start_val,
   input  logic [LW-1:0] pkt_len,
   input  logic          match_mode,
   input  logic          ext_start,
   output logic          sop_o,
   output logic          eop_o,
   output logic          hit_o,
   output logic          miss_o
);
   localparam logic [LW-1:0] ONE = LW'(1);

   logic          framed;
   logic [LW-1:0] cnt, pos;
   logic          is_match, expect_start, start, in_pkt;

   assign is_match     = byte_dat == start_val;
   assign expect_start = framed && (cnt == '0);

   always_comb begin
      if (match_mode) begin
         start  = byte_vld && !clr && is_match && (!framed || expect_start);
         miss_o = byte_vld && !clr && expect_start && !is_match;
         hit_o  = start;
      end else begin
         start  = ext_start && !clr;
         miss_o = 1'b0;
         hit_o  = byte_vld && !clr && is_match;
      end
      pos    = start ? '0 : cnt;
      in_pkt = byte_vld && !clr && (start || (framed && cnt != '0));
      sop_o  = start;
      eop_o  = in_pkt && (pos == pkt_len - ONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         framed <= 1'b0;
         cnt    <= '0;
      end else if (byte_vld) begin
         if (in_pkt) begin
            framed <= 1'b1;
            cnt    <= eop_o ? '0 : pos + ONE;
         end else begin
            framed <= 1'b0;
            cnt    <= '0;
         end
      end
   end

   // R7: the byte index never runs past the programmed length
   p_cnt_in_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (framed && !clr) |-> (cnt < pkt_len));
   // R10: a configuration change drops any framing
   p_clr_unframes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !framed);
endmodule

// File: rtl/tsync_lock.sv
module tsync_lock #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          hit,
   input  logic          miss,
   input  logic [CW-1:0] need,
   output logic          in_sync
);
   logic [CW-1:0] hits;

   always_ff @(posedge clk) begin
      if (!rst_n || clr || miss) hits <= '0;
      else if (hit && hits < need) hits <= hits + CW'(1);
   end

   assign in_sync = (need == '0) || (hits >= need);

   // R3: the match count saturates at the programmed value
   p_hits_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (hits <= need));
   // R9: a missed start empties the match count
   p_miss_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (miss && !clr) |=> (hits == '0));
endmodule

// File: rtl/tsync_top.sv
module tsync_top #(
   parameter int DW          = 8,
   parameter int LW          = 12,
   parameter int CW          = 4,
   parameter int HAS_EXT_SOP = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byte_vld,
   input  logic [DW-1:0]         byte_dat,
   input  logic                  ext_sop,
   input  logic [DW+LW+CW-1:0]   cfg_word,
   input  logic                  cfg_pol,
   input  logic [1:0]            cfg_mode,
   input  logic                  cfg_wide,
   output logic                  out_vld,
   output logic [DW-1:0]         out_dat,
   output logic                  out_sop,
   output logic                  out_eop,
   output logic                  in_sync
);
   import tsync_pkg::*;

   localparam int CFGW   = DW + LW + CW;
   localparam int LEN_LO = CW;
   localparam int SB_LO  = CW + LW;
   localparam int SHW    = CFGW + 4;

   generate
      if (DW < 1 || LW < 1 || CW < 1) begin : g_bad_width
         $error("tsync_top: field widths must be at least 1");
      end
      if (HAS_EXT_SOP != 0 && HAS_EXT_SOP != 1) begin : g_bad_opt
         $error("tsync_top: HAS_EXT_SOP must be 0 or 1");
      end
   endgenerate

   logic [DW-1:0]  start_val;
   logic [LW-1:0]  pkt_len;
   logic [CW-1:0]  need;
   logic [SHW-1:0] shadow, cfg_now;
   logic           chg, match_mode, ext_start;
   logic           sop_w, eop_w, hit_w, miss_w;

   assign start_val  = cfg_word[SB_LO +: DW];
   assign pkt_len    = cfg_word[LEN_LO +: LW];
   assign need       = cfg_word[0 +: CW];
   assign match_mode = is_match_mode(cfg_mode);
   assign cfg_now    = {cfg_word, cfg_pol, cfg_mode, cfg_wide};
   assign chg        = cfg_now != shadow;

   always_ff @(posedge clk) begin
      if (!rst_n) shadow <= '0;
      else        shadow <= cfg_now;
   end

   tsync_sop_detect #(.HAS_EXT(HAS_EXT_SOP)) u_sop (
      .clk(clk), .rst_n(rst_n), .clr(chg), .byte_vld(byte_vld),
      .ext_sop(ext_sop), .pol(cfg_pol), .wide(cfg_wide), .sop_now(ext_start)
   );

   tsync_framer #(.DW(DW), .LW(LW)) u_frm (
      .clk(clk), .rst_n(rst_n), .clr(chg), .byte_vld(byte_vld),
      .byte_dat(byte_dat), .start_val(start_val), .pkt_len(pkt_len),
      .match_mode(match_mode), .ext_start(ext_start),
      .sop_o(sop_w), .eop_o(eop_w), .hit_o(hit_w), .miss_o(miss_w)
   );

   tsync_lock #(.CW(CW)) u_lck (
      .clk(clk), .rst_n(rst_n), .clr(chg), .hit(hit_w), .miss(miss_w),
      .need(need), .in_sync(in_sync)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_dat <= '0;
         out_sop <= 1'b0;
         out_eop <= 1'b0;
      end else begin
         out_vld <= byte_vld;
         if (byte_vld) out_dat <= byte_dat;
         out_sop <= sop_w;
         out_eop <= eop_w;
      end
   end

   // R11: markers only travel with a valid byte
   p_markers_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sop || out_eop) |-> out_vld);
   // R8: in byte-match mode every start carries the start value
   p_match_start_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sop && $past(match_mode)) |-> (out_dat == $past(start_val)));
   // R10: the byte seen with a configuration change carries no marker
   p_chg_no_marker_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(chg) |-> (!out_sop && !out_eop));
endmodule

// File: tb/tsync_top_tb_top.sv
module tsync_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_dat = '0;
   logic        ext_sop = 1'b0;
   logic [23:0] cfg_word = '0;
   logic        cfg_pol = 1'b0;
   logic [1:0]  cfg_mode = '0;
   logic        cfg_wide = 1'b0;
   logic        out_vld, out_sop, out_eop, in_sync;
   logic [7:0]  out_dat;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   tsync_top dut_i (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
      .ext_sop(ext_sop), .cfg_word(cfg_word), .cfg_pol(cfg_pol),
      .cfg_mode(cfg_mode), .cfg_wide(cfg_wide), .out_vld(out_vld),
      .out_dat(out_dat), .out_sop(out_sop), .out_eop(out_eop), .in_sync(in_sync)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [7:0] sb, input logic [11:0] len, input logic [3:0] need,
                          input logic pol, input logic [1:0] mode, input logic wide,
                          input logic ext_idle);
      @(negedge clk);
      byte_vld = 1'b0;
      ext_sop  = ext_idle;
      cfg_word = {sb, len, need};
      cfg_pol  = pol;
      cfg_mode = mode;
      cfg_wide = wide;
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input logic s);
      @(negedge clk);
      byte_vld = 1'b0;
      ext_sop  = s;
      @(posedge clk);
      #1;
   endtask

   task automatic push(input string tag, input logic [7:0] d, input logic s,
                       input logic exp_sop, input logic exp_eop);
      @(negedge clk);
      byte_vld = 1'b1;
      byte_dat = d;
      ext_sop  = s;
      @(posedge clk);
      #1;
      check({tag, " sop"}, out_sop, exp_sop);
      check({tag, " eop"}, out_eop, exp_eop);
   endtask

   task automatic t_reset;
      cfg_word = {8'h47, 12'd6, 4'd1};
      repeat (3) @(posedge clk);
      #1;
      check("R12 vld", out_vld, 0);
      check("R12 sop/eop", {out_sop, out_eop}, 0);
      check("R12 sync", in_sync, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_zero_count;
      set_cfg(8'h47, 12'd6, 4'd0, 0, 2'd0, 0, 0);
      check("R2 sync idle", in_sync, 1);
      push("R2 a", 8'h00, 0, 0, 0);
      check("R2 sync a", in_sync, 1);
      check("R11 vld", out_vld, 1);
      check("R11 dat", out_dat, 8'h00);
      push("R2 b", 8'hFF, 0, 0, 0);
      check("R2 sync b", in_sync, 1);
      check("R11 dat b", out_dat, 8'hFF);
      idle(0);
      check("R11 vld idle", out_vld, 0);
      check("R11 dat held", out_dat, 8'hFF);
   endtask

   task automatic t_fields;
      set_cfg(8'hB8, 12'd3, 4'd1, 0, 2'd0, 0, 0);
      push("R1 s", 8'h47, 1, 1, 0);
      check("R1 no lock on 47", in_sync, 0);
      push("R1 m", 8'hB8, 0, 0, 0);
      check("R1 lock on B8", in_sync, 1);
      push("R1 eop idx2", 8'h01, 0, 0, 1);
   endtask

   task automatic t_ext_lock;
      set_cfg(8'h47, 12'd6, 4'd3, 0, 2'd0, 0, 0);
      for (int i = 0; i < 3; i++) begin
         push("R3 dec47", 8'h2F, 0, 0, 0);
         check("R3 2F no match", in_sync, 0);
      end
      push("R3 x", 8'h10, 0, 0, 0);
      push("R3 h1", 8'h47, 0, 0, 0);
      push("R3 y", 8'h55, 0, 0, 0);
      push("R3 h2", 8'h47, 0, 0, 0);
      check("R3 two hits", in_sync, 0);
      push("R3 h3", 8'h47, 0, 0, 0);
      check("R3 third hit locks", in_sync, 1);
   endtask

   task automatic t_ext_frame;
      set_cfg(8'h47, 12'd6, 4'd1, 0, 2'd1, 0, 0);
      push("R4 start", 8'hA0, 1, 1, 0);
      for (int i = 1; i < 6; i++) push("R7 body", 8'(i), 0, 0, i == 5);
      for (int i = 0; i < 7; i++) push("R7 no start", 8'h30 + 8'(i), 0, 0, 0);
      push("R4 s2", 8'hB0, 1, 1, 0);
      push("R4 b1", 8'hB1, 0, 0, 0);
      push("R4 b2", 8'hB2, 0, 0, 0);
      push("R4 restart", 8'hB3, 1, 1, 0);
      for (int i = 1; i < 6; i++) push("R4 recount", 8'hC0 + 8'(i), 0, 0, i == 5);
   endtask

   task automatic t_polarity;
      set_cfg(8'h47, 12'd6, 4'd1, 1, 2'd0, 0, 1);
      push("R5 low start", 8'h01, 0, 1, 0);
      push("R5 rise ignored", 8'h02, 1, 0, 0);
      push("R5 high held", 8'h03, 1, 0, 0);
      push("R5 low again", 8'h04, 0, 1, 0);
   endtask

   task automatic t_width;
      set_cfg(8'h47, 12'd6, 4'd1, 0, 2'd0, 1, 0);
      idle(1);
      push("R6 wide gap pulse", 8'h10, 0, 0, 0);
      push("R6 wide held", 8'h11, 1, 1, 0);
      push("R6 wide still high", 8'h12, 1, 0, 0);
      set_cfg(8'h47, 12'd6, 4'd1, 0, 2'd0, 0, 0);
      idle(1);
      push("R6 narrow gap pulse", 8'h20, 0, 1, 0);
   endtask

   task automatic t_match;
      set_cfg(8'h47, 12'd6, 4'd2, 0, 2'd3, 0, 0);
      push("R8 pin ignored", 8'h11, 1, 0, 0);
      check("R8 sync0", in_sync, 0);
      push("R8 first", 8'h47, 0, 1, 0);
      check("R8 one hit", in_sync, 0);
      push("R8 b1", 8'h01, 1, 0, 0);
      push("R8 inner 47", 8'h47, 0, 0, 0);
      check("R8 inner not counted", in_sync, 0);
      push("R8 b3", 8'h03, 1, 0, 0);
      push("R8 b4", 8'h04, 0, 0, 0);
      push("R8 end", 8'h05, 0, 0, 1);
      push("R8 second", 8'h47, 0, 1, 0);
      check("R8 lock", in_sync, 1);
      for (int i = 1; i < 6; i++) push("R8 body", 8'(i), 0, 0, i == 5);
      push("R9 miss", 8'h00, 0, 0, 0);
      check("R9 sync drops", in_sync, 0);
      push("R9 unframed", 8'h22, 0, 0, 0);
      push("R9 resume", 8'h47, 0, 1, 0);
      check("R9 count restarted", in_sync, 0);
   endtask

   task automatic t_cfg_change;
      set_cfg(8'h47, 12'd6, 4'd2, 0, 2'd0, 0, 0);
      push("R10 h1", 8'h47, 0, 0, 0);
      push("R10 h2", 8'h47, 0, 0, 0);
      check("R10 locked", in_sync, 1);
      push("R10 start", 8'h60, 1, 1, 0);
      push("R10 p1", 8'h61, 0, 0, 0);
      push("R10 p2", 8'h62, 0, 0, 0);
      set_cfg(8'h47, 12'd6, 4'd2, 0, 2'd0, 1, 0);
      check("R10 lock cleared", in_sync, 0);
      for (int i = 3; i < 8; i++) push("R10 framing cleared", 8'h60 + 8'(i), 0, 0, 0);
      push("R10 h1b", 8'h47, 0, 0, 0);
      check("R10 recount", in_sync, 0);
      push("R10 h2b", 8'h47, 0, 0, 0);
      check("R10 relock", in_sync, 1);
   endtask

   initial begin
      t_reset();
      t_zero_count();
      t_fields();
      t_ext_lock();
      t_ext_frame();
      t_polarity();
      t_width();
      t_match();
      t_cfg_change();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #800000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule